// File: doc/BRIEF.md
# Audio Delay-Line DRAM Controller

This block drives a bank of external asynchronous DRAM that holds the delay line for echo, reverberation and surround effects. A processing core presents one access at a time: a channel number, an address, a read or write flag and write data. The controller runs each access as a slot of fixed length. Inside that slot it multiplexes the row and then the column onto the address pins, sequences the row and column strobes, and pulses a read or a write strobe. Read data comes back with a one-cycle valid pulse after the slot ends.

Every channel may make at most 16 accesses between two frame strobes. A frame strobe marks the start of a sample period. A request beyond that budget is dropped and an overflow pulse is raised. When the controller is idle, has no request and the refresh interval has run out, it runs a refresh slot in which the column strobe falls before the row strobe. Two live mode pins set the memory size and the data width. With the small device, 8 address bits are used. With the large device, 9 address bits are used. The data path is 4 bits wide with one device or 8 bits wide with two devices side by side.

Top module: `dly_mem_ctrl`

## Requirements
- R1: While reset is held and after it is released, the RAS, CAS, read and write strobes (all active low) are high, `dram_dq_oe_o` is 0, `rd_valid_o` and `ovf_o` are 0, and `req_ready_o` is 1.
- R2: An accepted request starts a 13-cycle slot in the cycle after the accepting edge. Counting slot cycles k=0..12: RAS is low from k=5, CAS is low from k=7, the row address is on the pins for k<=5 and the column address for k>=6. After k=12 all strobes return high and `req_ready_o` returns to 1.
- R3: Each channel accepts at most 16 requests between frame strobes. A 17th request is handshaken but not executed: `ovf_o` is 1 for one cycle after the accepting edge, and no read or write strobe follows.
- R4: `frame_i` restores every channel's budget. A request that is accepted in the same cycle as `frame_i` counts as the first access of the new frame.
- R5: Each channel has its own budget, so exhausting one channel does not block another.
- R6: With `big_dev_i`=0 the row is address bits [15:8] and the column is bits [7:0], and address pin 8 stays low.
- R7: With `big_dev_i`=1 the row is address bits [17:9] and the column is bits [8:0].
- R8: In a write slot, the write strobe is low exactly for k>=7 and the read strobe stays high. `dram_dq_oe_o` equals the lane mask for k>=6 and is 0 otherwise, and `dram_dq_o` carries the write data on the enabled lanes. The lane mask is 8'hFF with `dual_dev_i`=1 and 8'h0F with `dual_dev_i`=0.
- R9: In a read slot, the read strobe is low exactly for k>=7 and the write strobe stays high. `dram_dq_i` is sampled at k=12. In the next cycle `rd_valid_o` is 1 for one cycle and `rd_data_o` holds the sample ANDed with the lane mask.
- R10: Once `REF_PERIOD` cycles have passed since the previous refresh was due, an idle controller with no request runs a refresh slot. CAS goes low one cycle before RAS, both stay low until the slot ends, the read and write strobes stay high, no data lane is driven, and `req_ready_o` is 0.
- R11: The read and write strobes are never low at the same time. Outside refresh, CAS only goes low while RAS is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Sample-period strobe; restores the access budgets |
| big_dev_i | input | 1 | 1: 9-bit multiplexed address, 0: 8-bit |
| dual_dev_i | input | 1 | 1: 8-bit data path, 0: 4-bit data path |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle; request taken at this edge |
| req_ch_i | input | 1 | Channel of the request |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 18 | Linear delay-line address |
| req_wdata_i | input | 8 | Write data |
| ovf_o | output | 1 | Pulse: request rejected by the budget |
| rd_valid_o | output | 1 | Pulse: read data valid |
| rd_data_o | output | 8 | Read data |
| dram_a_o | output | 9 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_rd_no | output | 1 | Read strobe, active low |
| dram_wr_no | output | 1 | Write strobe, active low |
| dram_dq_o | output | 8 | Data to memory |
| dram_dq_oe_o | output | 8 | Per-lane output enable |
| dram_dq_i | input | 8 | Data from memory |

## Verification
The assertions check the strobe rules on every cycle. These cover the exclusive read and write strobes, RAS low before CAS in an access slot, the minimum RAS low and precharge spans, a quiet data bus during refresh, the upper lanes staying off in the 4-bit mode, and pin 8 staying low in the small mode. They also tie `ovf_o` and `rd_valid_o` back to the handshake or read strobe that caused them. Only the bench scenarios can show the cycle-exact shape of a slot, which address bits land in the row and which in the column, the data returned, and the budget counting. The budget checks cover the 17th request of a frame, a second channel that is still free, and a frame strobe given in the same cycle as a request. The refresh scenario shows that an idle controller refreshes on its own.

// File: rtl/dly_mem_pkg.sv
package dly_mem_pkg;
  typedef enum logic {SK_ACC = 1'b0, SK_REF = 1'b1} slot_kind_e;
endpackage

// File: rtl/dly_slot_seq.sv
module dly_slot_seq
  import dly_mem_pkg::*;
#(
  parameter int PRE_CYC  = 5,
  parameter int CASL_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_acc_i,
  input  logic start_ref_i,
  input  logic we_i,
  output logic busy_o,
  output logic ras_no,
  output logic cas_no,
  output logic rd_no,
  output logic wr_no,
  output logic col_sel_o,
  output logic drive_o,
  output logic capture_o
);
  localparam int SLOT_CYC = PRE_CYC + 2 + CASL_CYC;
  localparam int CW = $clog2(SLOT_CYC);

  logic          busy_q, we_q;
  slot_kind_e    kind_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      kind_q <= SK_ACC;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_acc_i || start_ref_i) begin
        busy_q <= 1'b1;
        kind_q <= start_acc_i ? SK_ACC : SK_REF;
        we_q   <= start_acc_i & we_i;
        cnt_q  <= '0;
      end
    end else if (cnt_q == CW'(SLOT_CYC - 1)) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  logic ph_ras, ph_mid, ph_cas, is_acc;
  assign ph_ras = busy_q && (cnt_q >= CW'(PRE_CYC));
  assign ph_mid = busy_q && (cnt_q >= CW'(PRE_CYC + 1));
  assign ph_cas = busy_q && (cnt_q >= CW'(PRE_CYC + 2));
  assign is_acc = (kind_q == SK_ACC);

  // refresh: CAS leads RAS by one cycle
  assign ras_no    = is_acc ? !ph_ras : !ph_mid;
  assign cas_no    = is_acc ? !ph_cas : !ph_ras;
  assign rd_no     = !(is_acc && ph_cas && !we_q);
  assign wr_no     = !(is_acc && ph_cas && we_q);
  assign col_sel_o = ph_mid;
  assign drive_o   = is_acc && ph_mid && we_q;
  assign capture_o = busy_q && is_acc && !we_q && (cnt_q == CW'(SLOT_CYC - 1));
  assign busy_o    = busy_q;
endmodule

// File: rtl/dly_budget.sv
module dly_budget #(
  parameter int CH_NUM = 2,
  parameter int BUDGET = 16,
  localparam int CH_W  = (CH_NUM > 1) ? $clog2(CH_NUM) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_i,
  input  logic            take_i,
  input  logic [CH_W-1:0] ch_i,
  output logic            ok_o
);
  localparam int CW = $clog2(BUDGET + 1);

  logic [CW-1:0] cnt_q [CH_NUM];
  logic [CW-1:0] eff;

  assign eff  = frame_i ? '0 : cnt_q[ch_i];
  assign ok_o = eff < CW'(BUDGET);

  for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
    logic hit;
    assign hit = take_i && ok_o && (ch_i == CH_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q[g] <= '0;
      else if (frame_i) cnt_q[g] <= hit ? CW'(1) : '0;
      else if (hit)     cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end
endmodule

// File: rtl/dly_refresh_timer.sv
module dly_refresh_timer #(
  parameter int REF_PERIOD = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic due_o
);
  localparam int TW = $clog2(REF_PERIOD + 1);

  logic [TW-1:0] t_q;
  logic          due_q, wrap;

  assign wrap = (t_q == TW'(REF_PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q   <= '0;
      due_q <= 1'b0;
    end else begin
      t_q   <= wrap ? '0 : t_q + 1'b1;
      due_q <= wrap ? 1'b1 : (clr_i ? 1'b0 : due_q);
    end
  end

  assign due_o = due_q;
endmodule

// File: rtl/dly_mem_ctrl.sv
module dly_mem_ctrl #(
  parameter int CH_NUM     = 2,
  parameter int BUDGET     = 16,
  parameter int A_W        = 9,
  parameter int D_W        = 8,
  parameter int PRE_CYC    = 5,
  parameter int CASL_CYC   = 6,
  parameter int REF_PERIOD = 780,
  localparam int CH_W      = (CH_NUM > 1) ? $clog2(CH_NUM) : 1,
  localparam int ADDR_W    = 2 * A_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              big_dev_i,
  input  logic              dual_dev_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CH_W-1:0]   req_ch_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [D_W-1:0]    req_wdata_i,
  output logic              ovf_o,
  output logic              rd_valid_o,
  output logic [D_W-1:0]    rd_data_o,
  output logic [A_W-1:0]    dram_a_o,
  output logic              dram_ras_no,
  output logic              dram_cas_no,
  output logic              dram_rd_no,
  output logic              dram_wr_no,
  output logic [D_W-1:0]    dram_dq_o,
  output logic [D_W-1:0]    dram_dq_oe_o,
  input  logic [D_W-1:0]    dram_dq_i
);
  localparam int HALF = D_W / 2;

  logic busy, hs, ok, start_acc, start_ref, due;
  logic col_sel, drive, capture;

  assign req_ready_o = !busy;
  assign hs          = req_valid_i && !busy;
  assign start_acc   = hs && ok;
  assign start_ref   = !busy && due && !start_acc;

  dly_budget #(.CH_NUM(CH_NUM), .BUDGET(BUDGET)) u_budget (
    .clk_i, .rst_ni, .frame_i,
    .take_i(hs), .ch_i(req_ch_i), .ok_o(ok)
  );

  dly_refresh_timer #(.REF_PERIOD(REF_PERIOD)) u_ref (
    .clk_i, .rst_ni, .clr_i(start_ref), .due_o(due)
  );

  dly_slot_seq #(.PRE_CYC(PRE_CYC), .CASL_CYC(CASL_CYC)) u_seq (
    .clk_i, .rst_ni,
    .start_acc_i(start_acc), .start_ref_i(start_ref), .we_i(req_we_i),
    .busy_o(busy), .ras_no(dram_ras_no), .cas_no(dram_cas_no),
    .rd_no(dram_rd_no), .wr_no(dram_wr_no),
    .col_sel_o(col_sel), .drive_o(drive), .capture_o(capture)
  );

  logic [ADDR_W-1:0] addr_q;
  logic [D_W-1:0]    wdata_q, rdata_q;
  logic              ovf_q, rdv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ovf_q   <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      if (start_acc) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (capture) rdata_q <= dram_dq_i & lane_mask;
      ovf_q <= hs && !ok;
      rdv_q <= capture;
    end
  end

  logic [D_W-1:0] lane_mask;
  assign lane_mask = dual_dev_i ? '1 : D_W'((1 << HALF) - 1);

  // row/column split follows the device size
  logic [A_W-1:0] row, col;
  always_comb begin
    if (big_dev_i) begin
      row = addr_q[ADDR_W-1:A_W];
      col = addr_q[A_W-1:0];
    end else begin
      row = {1'b0, addr_q[ADDR_W-3:A_W-1]};
      col = {1'b0, addr_q[A_W-2:0]};
    end
  end

  assign dram_a_o     = col_sel ? col : row;
  assign dram_dq_o    = wdata_q & lane_mask;
  assign dram_dq_oe_o = drive ? lane_mask : '0;
  assign ovf_o        = ovf_q;
  assign rd_valid_o   = rdv_q;
  assign rd_data_o    = rdata_q;
endmodule

// File: rtl/dly_mem_ctrl_chk.sv
module dly_mem_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       big_dev_i,
  input logic       dual_dev_i,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       ovf_o,
  input logic       rd_valid_o,
  input logic [8:0] dram_a_o,
  input logic       dram_ras_no,
  input logic       dram_cas_no,
  input logic       dram_rd_no,
  input logic       dram_wr_no,
  input logic [7:0] dram_dq_oe_o
);
  p_rdwr_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dram_rd_no && !dram_wr_no));

  p_cas_after_ras_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_no) && !dram_ras_no) |-> $past(!dram_ras_no));

  p_ras_low_span_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |=> !dram_ras_no);

  p_ras_precharge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_ras_no) |=> dram_ras_no);

  p_cbr_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_cas_no && dram_ras_no) |->
      (dram_dq_oe_o == 8'h00 && dram_rd_no && dram_wr_no && !req_ready_o));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(req_valid_i && req_ready_o));

  p_rd_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(!dram_rd_no));

  p_narrow_lanes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dual_dev_i |-> dram_dq_oe_o[7:4] == 4'h0);

  p_small_a8_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !big_dev_i |-> !dram_a_o[8]);
endmodule

bind dly_mem_ctrl dly_mem_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .big_dev_i(big_dev_i), .dual_dev_i(dual_dev_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .ovf_o(ovf_o),
  .rd_valid_o(rd_valid_o), .dram_a_o(dram_a_o), .dram_ras_no(dram_ras_no),
  .dram_cas_no(dram_cas_no), .dram_rd_no(dram_rd_no), .dram_wr_no(dram_wr_no),
  .dram_dq_oe_o(dram_dq_oe_o)
);

// File: tb/dly_mem_ctrl_test.sv
module dly_mem_ctrl_test;
  localparam int REF_P = 400;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        frame_i = 0, big_dev_i = 0, dual_dev_i = 0;
  logic        req_valid_i = 0, req_ch_i = 0, req_we_i = 0;
  logic [17:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0, dram_dq_i = '0;
  logic        req_ready_o, ovf_o, rd_valid_o;
  logic [7:0]  rd_data_o, dram_dq_o, dram_dq_oe_o;
  logic [8:0]  dram_a_o;
  logic        dram_ras_no, dram_cas_no, dram_rd_no, dram_wr_no;

  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  dly_mem_ctrl #(.REF_PERIOD(REF_P)) uut (
    .clk_i, .rst_ni, .frame_i, .big_dev_i, .dual_dev_i,
    .req_valid_i, .req_ready_o, .req_ch_i, .req_we_i, .req_addr_i, .req_wdata_i,
    .ovf_o, .rd_valid_o, .rd_data_o, .dram_a_o, .dram_ras_no, .dram_cas_no,
    .dram_rd_no, .dram_wr_no, .dram_dq_o, .dram_dq_oe_o, .dram_dq_i
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one request; checks the whole slot when accepted
  task automatic do_access(input bit ch, input bit we, input logic [17:0] addr,
                           input logic [7:0] wd, input bit with_frame,
                           input bit exp_acc, input string req);
    logic [8:0] row, col, ea;
    logic [7:0] mask, eoe;
    bit bad_t, bad_a, bad_s;
    logic [31:0] a_t, a_a, a_s;
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1; req_ch_i = ch; req_we_i = we; req_addr_i = addr;
    req_wdata_i = wd; frame_i = with_frame;
    @(posedge clk_i); @(negedge clk_i);
    req_valid_i = 0; frame_i = 0;
    if (!exp_acc) begin
      chk(ovf_o == 1'b1, "R3", "ovf after rejected request", ovf_o, 1);
      bad_s = 0;
      for (int k = 0; k < 13; k++) begin
        if (!dram_wr_no || !dram_rd_no) bad_s = 1;
        @(negedge clk_i);
      end
      chk(!bad_s, "R3", "no strobe for rejected request", bad_s, 0);
      return;
    end
    chk(ovf_o == 1'b0, req, "no ovf on accepted request", ovf_o, 0);
    row  = big_dev_i ? addr[17:9] : {1'b0, addr[15:8]};
    col  = big_dev_i ? addr[8:0]  : {1'b0, addr[7:0]};
    mask = dual_dev_i ? 8'hFF : 8'h0F;
    bad_t = 0; bad_a = 0; bad_s = 0; a_t = 0; a_a = 0; a_s = 0;
    for (int k = 0; k < 13; k++) begin
      ea  = (k >= 6) ? col : row;
      eoe = (we && k >= 6) ? mask : 8'h00;
      if (dram_ras_no != (k < 5) || dram_cas_no != (k < 7) || req_ready_o) begin
        if (!bad_t) a_t = k; bad_t = 1;
      end
      if (dram_a_o != ea) begin
        if (!bad_a) a_a = {k[7:0], 7'd0, dram_a_o}; bad_a = 1;
      end
      if (dram_wr_no != !(we && k >= 7) || dram_rd_no != !(!we && k >= 7) ||
          dram_dq_oe_o != eoe || ((dram_dq_o ^ wd) & eoe) != 8'h00) begin
        if (!bad_s) a_s = k; bad_s = 1;
      end
      @(negedge clk_i);
    end
    chk(!bad_t, "R2", "RAS/CAS slot shape (first bad cycle)", a_t, 32'hFFFF);
    chk(!bad_a, big_dev_i ? "R7" : "R6", "row/col address (cycle,addr)", a_a, {row, col});
    chk(!bad_s, we ? "R8" : "R9", "strobes and data lanes (first bad cycle)", a_s, 32'hFFFF);
    chk(req_ready_o == 1'b1, "R2", "ready after slot", req_ready_o, 1);
    if (we) chk(rd_valid_o == 1'b0, "R8", "no read valid on write", rd_valid_o, 0);
    else begin
      chk(rd_valid_o == 1'b1, "R9", "read valid", rd_valid_o, 1);
      chk(rd_data_o == (dram_dq_i & mask), "R9", "read data", rd_data_o, dram_dq_i & mask);
      @(negedge clk_i);
      chk(rd_valid_o == 1'b0, "R9", "read valid is one cycle", rd_valid_o, 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(dram_ras_no && dram_cas_no && dram_rd_no && dram_wr_no, "R1",
        "strobes high in reset", {dram_ras_no, dram_cas_no, dram_rd_no, dram_wr_no}, 4'hF);
    chk(dram_dq_oe_o == 0 && !rd_valid_o && !ovf_o && req_ready_o, "R1",
        "idle outputs in reset", {dram_dq_oe_o, rd_valid_o, ovf_o, req_ready_o}, 1);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk(dram_ras_no && dram_cas_no && req_ready_o && !ovf_o, "R1", "idle after release",
        {dram_ras_no, dram_cas_no, req_ready_o, ovf_o}, 4'hE);
  endtask

  task automatic t_small();
    big_dev_i = 0; dual_dev_i = 0; dram_dq_i = 8'hC6;
    do_access(0, 1, 18'h2_AB3C, 8'h5A, 0, 1, "R8");
    do_access(1, 0, 18'h1_7E01, 8'h00, 0, 1, "R9");
  endtask

  task automatic t_big();
    big_dev_i = 1; dual_dev_i = 1; dram_dq_i = 8'h9D;
    do_access(0, 1, 18'h3_5A5F, 8'hE7, 0, 1, "R7");
    do_access(1, 0, 18'h2_01FF, 8'h00, 0, 1, "R7");
    big_dev_i = 0;
  endtask

  task automatic t_budget();
    big_dev_i = 0; dual_dev_i = 1;
    @(negedge clk_i); frame_i = 1; @(negedge clk_i); frame_i = 0;
    for (int i = 0; i < 16; i++) do_access(0, 1, 18'(i * 4099), 8'(i), 0, 1, "R3");
    do_access(0, 1, 18'h0_1234, 8'h11, 0, 0, "R3");
    do_access(1, 1, 18'h0_4321, 8'h22, 0, 1, "R5");
    do_access(0, 1, 18'h0_0F0F, 8'h33, 1, 1, "R4");
    do_access(0, 0, 18'h0_0F0F, 8'h00, 0, 1, "R4");
  endtask

  task automatic t_refresh();
    bit seen = 0;
    int n = 0;
    while (!seen && n < 2 * REF_P) begin
      @(negedge clk_i); n++;
      if (!dram_cas_no && dram_ras_no) seen = 1;
    end
    chk(seen, "R10", "refresh began within interval", n, REF_P);
    chk(!req_ready_o && dram_dq_oe_o == 0 && dram_rd_no && dram_wr_no, "R10",
        "first refresh cycle quiet", {req_ready_o, dram_dq_oe_o}, 0);
    @(negedge clk_i);
    chk(!dram_ras_no && !dram_cas_no, "R10", "RAS follows CAS", {dram_ras_no, dram_cas_no}, 0);
    while (!req_ready_o) @(negedge clk_i);
    chk(dram_ras_no && dram_cas_no, "R10", "strobes high after refresh",
        {dram_ras_no, dram_cas_no}, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_small();
    t_big();
    t_budget();
    t_refresh();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule